// File: doc/BRIEF.md
# Time-Multiplexed Voice Output Sequencer

This block feeds the analog back end of an eight-voice sample player that shares one digital-to-analog converter across all voices. Each voice keeps its latest 8-bit companded sample and a volume byte in small registers, written through a strobe-qualified port. A sample-rate tick starts a sequence that visits the voices in ascending order, one time slot each.

In every slot three serial words go out on a shared clock and data line, and each word has its own active-low chip select. The first word is a one-hot channel-select word that picks the analog hold stage. The second is the voice's volume byte. The last is the expanded 12-bit converter word. The converter's select rises last, so its new value settles into the hold stage that was just chosen.

The companded byte holds a sign, a 3-bit segment and a 4-bit mantissa. It is expanded by rule into offset-binary form. The whole sequence has a fixed length, so the tick period can be set with a known margin. A tick that arrives while a sequence is still running is dropped and recorded.

Top module: `voice_out_seq`

## Requirements
- R1: Right after reset, all three chip selects are high, `sclk` and `mosi` are low, and `busy` and `overrun` are low.
- R2: A code with bit 7 = s, bits 6:4 = e and bits 3:0 = m expands to g = (((2m+33) << e) - 33) >> 2. The converter word is 2048+g when s=1 and 2047-g when s=0.
- R3: Slots run for voices 0 to NV-1 in ascending order. Within each slot the order is channel-select word, then volume word, then converter word.
- R4: The channel-select word is NV bits wide and has only bit v set. The volume word is the VOL_W-bit volume stored for voice v. The converter word is 12 bits wide.
- R5: Serial transfers use mode 0 and send the most significant bit first. `sclk` idles low. `mosi` changes only while `sclk` is low. The `sclk` period is CLK_DIV system clocks.
- R6: At most one chip select is low at any time. While a select is low, `sclk` rises exactly once for each bit of that word.
- R7: `busy` rises on the clock after a tick that arrives while the block is idle. It stays high for exactly NV*((NV+VOL_W+12)*CLK_DIV + 3*CLK_DIV/2) cycles, and all selects are high whenever `busy` is low.
- R8: A tick that arrives while `busy` is high sets `overrun`, which stays set until reset. The running sequence continues unchanged and no extra sequence starts.
- R9: A write with `smp_wr` high stores `smp_code` and `smp_vol` for voice `smp_voice`. A sequence sends the most recently written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Sample-rate tick, one cycle wide |
| smp_wr | input | 1 | Sample write strobe |
| smp_voice | input | $clog2(NV) | Voice index for the write |
| smp_code | input | 8 | Companded sample code |
| smp_vol | input | VOL_W | Volume byte |
| sclk | output | 1 | Shared serial clock |
| mosi | output | 1 | Shared serial data |
| cs_sel_n | output | 1 | Channel-select chip select, active low |
| cs_vol_n | output | 1 | Volume chip select, active low |
| cs_dac_n | output | 1 | Converter chip select, active low |
| busy | output | 1 | Sequence in progress |
| overrun | output | 1 | Sticky flag for a dropped tick |

## Verification
The assertions check the bus-level rules on every cycle: only one select is active, `sclk` stays idle low, data holds while `sclk` is high, the bus is quiet when the block is idle, and `overrun` is set and then sticks. The bench's scenarios show what only whole frames reveal. These are the expansion of all 256 codes, the slot and word order, the word contents and bit counts, the exact sequence length, the use of the last value written, and the fact that a dropped tick neither restarts nor lengthens a sequence.

// File: rtl/voice_out_seq.sv
module voice_out_seq #(
  parameter int NV      = 8,
  parameter int VOL_W   = 8,
  parameter int CLK_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  smp_wr,
  input  logic [$clog2(NV)-1:0] smp_voice,
  input  logic [7:0]            smp_code,
  input  logic [VOL_W-1:0]      smp_vol,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_sel_n,
  output logic                  cs_vol_n,
  output logic                  cs_dac_n,
  output logic                  busy,
  output logic                  overrun
);
  localparam int VW   = $clog2(NV);
  localparam int HALF = CLK_DIV / 2;
  localparam int DC_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SH_A = (NV > VOL_W) ? NV : VOL_W;
  localparam int SH_W = (SH_A > 12) ? SH_A : 12;
  localparam int BC_W = $clog2(SH_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t             st;
  logic [7:0]      code_q [NV];
  logic [VOL_W-1:0] vol_q [NV];
  logic [VW-1:0]   v;
  logic [1:0]      ph;
  logic [SH_W-1:0] sh;
  logic [BC_W-1:0] bc, len_q;
  logic [DC_W-1:0] dc;
  logic            sclk_q, ovr_q;
  logic [2:0]      csn_q;

  wire half_end  = (dc == DC_W'(HALF - 1));
  wire last_slot = (ph == 2'd2) && (v == VW'(NV - 1));

  logic [1:0]      ld_ph;
  logic [VW-1:0]   ld_v;
  logic [SH_W-1:0] ld_word;
  logic [BC_W-1:0] ld_len;
  logic [7:0]      c;
  logic [12:0]     mag;
  logic [10:0]     g;

  always_comb begin
    if (st == S_IDLE) begin
      ld_ph = 2'd0;
      ld_v  = '0;
    end else begin
      ld_ph = (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      ld_v  = (ph == 2'd2) ? v + VW'(1) : v;
    end
    c   = code_q[ld_v];
    mag = ((13'(c[3:0]) << 1) + 13'd33) << c[6:4];
    mag = mag - 13'd33;
    g   = mag[12:2];
    case (ld_ph)
      2'd0: begin
        ld_word = SH_W'(NV'(1) << ld_v) << (SH_W - NV);
        ld_len  = BC_W'(NV);
      end
      2'd1: begin
        ld_word = SH_W'(vol_q[ld_v]) << (SH_W - VOL_W);
        ld_len  = BC_W'(VOL_W);
      end
      default: begin
        ld_word = SH_W'(c[7] ? {1'b1, g} : {1'b0, ~g}) << (SH_W - 12);
        ld_len  = BC_W'(12);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NV; i++) begin
        code_q[i] <= '0;
        vol_q[i]  <= '0;
      end
      st     <= S_IDLE;
      v      <= '0;
      ph     <= '0;
      sh     <= '0;
      bc     <= '0;
      len_q  <= '0;
      dc     <= '0;
      sclk_q <= 1'b0;
      csn_q  <= 3'b111;
      ovr_q  <= 1'b0;
    end else begin
      if (smp_wr) begin
        code_q[smp_voice] <= smp_code;
        vol_q[smp_voice]  <= smp_vol;
      end
      if (tick && st != S_IDLE) ovr_q <= 1'b1;
      case (st)
        S_IDLE: if (tick) begin
          st <= S_XFER; ph <= ld_ph; v <= ld_v; sh <= ld_word; len_q <= ld_len;
          bc <= '0; dc <= '0; sclk_q <= 1'b0; csn_q <= ~(3'b001 << ld_ph);
        end
        S_XFER: if (half_end) begin
          dc     <= '0;
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            if (bc == len_q - BC_W'(1)) begin
              st    <= S_GAP;
              csn_q <= 3'b111;
            end else begin
              sh <= sh << 1;
              bc <= bc + BC_W'(1);
            end
          end
        end else dc <= dc + DC_W'(1);
        default: if (half_end) begin
          dc <= '0;
          if (last_slot) st <= S_IDLE;
          else begin
            st <= S_XFER; ph <= ld_ph; v <= ld_v; sh <= ld_word; len_q <= ld_len;
            bc <= '0; sclk_q <= 1'b0; csn_q <= ~(3'b001 << ld_ph);
          end
        end else dc <= dc + DC_W'(1);
      endcase
    end
  end

  assign sclk     = sclk_q;
  assign mosi     = (st == S_XFER) & sh[SH_W-1];
  assign cs_sel_n = csn_q[0];
  assign cs_vol_n = csn_q[1];
  assign cs_dac_n = csn_q[2];
  assign busy     = (st != S_IDLE);
  assign overrun  = ovr_q;
endmodule

// File: rtl/voice_out_seq_chk.sv
module voice_out_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic sclk,
  input logic mosi,
  input logic cs_sel_n,
  input logic cs_vol_n,
  input logic cs_dac_n,
  input logic busy,
  input logic overrun
);
  wire all_hi = cs_sel_n & cs_vol_n & cs_dac_n;

  // R6
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~cs_sel_n, ~cs_vol_n, ~cs_dac_n}));
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_hi |-> !sclk);
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> all_hi);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy) |=> busy);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy) |=> overrun);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind voice_out_seq voice_out_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sclk(sclk), .mosi(mosi),
  .cs_sel_n(cs_sel_n), .cs_vol_n(cs_vol_n), .cs_dac_n(cs_dac_n),
  .busy(busy), .overrun(overrun)
);

// File: tb/tb_voice_out_seq.sv
`timescale 1ns/1ps
module tb_voice_out_seq;
  localparam int NV = 8, VOL_W = 8, CLK_DIV = 4;
  localparam int SEQ_LEN = NV * ((NV + VOL_W + 12) * CLK_DIV + 3 * (CLK_DIV / 2));

  logic clk = 0, rst_n = 0, tick = 0, smp_wr = 0;
  logic [2:0] smp_voice = 0;
  logic [7:0] smp_code = 0, smp_vol = 0;
  logic sclk, mosi, cs_sel_n, cs_vol_n, cs_dac_n, busy, overrun;

  int vectors = 0, fails = 0;
  logic [7:0] codes [NV];
  logic [7:0] vols [NV];

  int   n = 0, kind = 3, nb = 0;
  logic [15:0] acc = 0;
  bit   logging = 0;
  time  last_rise = 0;
  int   log_kind [64];
  int   log_nb [64];
  logic [15:0] log_word [64];

  always #2 clk = ~clk;

  voice_out_seq #(.NV(NV), .VOL_W(VOL_W), .CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .smp_wr(smp_wr), .smp_voice(smp_voice),
    .smp_code(smp_code), .smp_vol(smp_vol), .sclk(sclk), .mosi(mosi),
    .cs_sel_n(cs_sel_n), .cs_vol_n(cs_vol_n), .cs_dac_n(cs_dac_n),
    .busy(busy), .overrun(overrun));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_dac(input logic [7:0] cd);
    int g;
    g = ((((2 * int'(cd[3:0])) + 33) << cd[6:4]) - 33) >> 2;
    return cd[7] ? 2048 + g : 2047 - g;
  endfunction

  always @(posedge sclk) begin
    if (!cs_sel_n) kind = 0;
    else if (!cs_vol_n) kind = 1;
    else if (!cs_dac_n) kind = 2;
    else kind = 3;
    acc = {acc[14:0], mosi};
    nb++;
    if (nb > 1) chk("R5 sclk period ns", int'($time - last_rise), CLK_DIV * 4);
    last_rise = $time;
  end

  always @(posedge cs_sel_n or posedge cs_vol_n or posedge cs_dac_n) begin
    if (logging && n < 64) begin
      log_kind[n] = kind;
      log_word[n] = acc;
      log_nb[n] = nb;
      n++;
    end
    acc = 0;
    nb = 0;
  end

  task automatic wr(input int vc, input int cd, input int vl);
    @(negedge clk);
    smp_wr = 1; smp_voice = 3'(vc); smp_code = 8'(cd); smp_vol = 8'(vl);
    @(negedge clk);
    smp_wr = 0;
  endtask

  task automatic run_seq(input int base, input bit dbl);
    int cnt;
    for (int v = 0; v < NV; v++) begin
      codes[v] = 8'(base + v);
      vols[v]  = 8'(v * 37 + base * 5 + 1);
      wr(v, ~(base + v), 8'hA5);        // R9: overwritten below
      wr(v, codes[v], vols[v]);
    end
    n = 0;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      @(negedge clk);
      tick = (dbl && cnt == 100);
    end
    tick = 0;
    chk("R7 busy length", cnt, SEQ_LEN);
    chk("R8 transfer count", n, 3 * NV);
    for (int v = 0; v < NV; v++) begin
      chk("R3 order sel", log_kind[3*v],   0);
      chk("R3 order vol", log_kind[3*v+1], 1);
      chk("R3 order dac", log_kind[3*v+2], 2);
      chk("R6 bits sel", log_nb[3*v],   NV);
      chk("R6 bits vol", log_nb[3*v+1], VOL_W);
      chk("R6 bits dac", log_nb[3*v+2], 12);
      chk("R4 sel word", int'(log_word[3*v] & 16'hFF), 1 << v);
      chk("R9 R4 vol word", int'(log_word[3*v+1] & 16'hFF), int'(vols[v]));
      chk("R2 dac word", int'(log_word[3*v+2] & 16'hFFF), exp_dac(codes[v]));
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cs_sel_n", cs_sel_n, 1);
    chk("R1 cs_vol_n", cs_vol_n, 1);
    chk("R1 cs_dac_n", cs_dac_n, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 0);
    chk("R1 busy", busy, 0);
    chk("R1 overrun", overrun, 0);
    logging = 1;
    for (int b = 0; b < 256; b += NV) run_seq(b, 0);
    chk("R8 no overrun on clean ticks", overrun, 0);
    run_seq(3, 1);
    chk("R8 overrun set", overrun, 1);
    run_seq(77, 0);
    chk("R8 overrun sticky", overrun, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule